// File: doc/BRIEF.md
# Flash Host Command Sequencer

This block is a bus master on the host side. It drives a memory-mapped flash controller through single-cycle register writes and reads. The host starts one of four operations by giving an operation code and a packed 32-bit device address. The operations are page-read prologue, page-write prologue, page program and block erase. The sequencer then plays a fixed script of register accesses. A script is made of sequence-code writes, command writes, zero writes to a dedicated no-op register, address byte writes and ready polls. The no-op writes cannot be swapped for idle cycles, because the controller depends on them for its timing.

Program and erase end with a status phase. The sequencer flushes the controller, switches the ECC configuration into read mode, and reads three status words. If any of the three differs from its expected good value, a sticky fail flag is set. Register offsets, command codes, the ready bit and the good status values are all parameters. Moving page data, ECC and bad-block handling are the job of other blocks.

Top module: `flash_cmd_seq`

## Requirements
- R1: A request (`reqValid` high) is taken only while `busy` is low, and `busy` rises on the following cycle. A request that arrives while `busy` is high has no effect on the bus access stream. After reset `busy`, `done` and `failFlag` are low and no bus access is made.
- R2: Every operation starts with the same reset script: control register written with the chip-enable value, sequence register written with the reset sequence code, command register written with the reset command, two no-op writes, a ready poll, and one more no-op write.
- R3: A ready poll reads the control register once and ignores the value, even if the ready bit is set. It then keeps reading the control register, one read per cycle, until a read has the ready bit set. A poll therefore takes at least two reads.
- R4: A full address goes to the address register as four byte writes, starting with bits 7:0 and ending with bits 31:24. Each byte is zero-extended to the data width.
- R5: The page-read prologue runs as follows after the reset script:
  - read sequence code, then read command;
  - one no-op, then the four address bytes;
  - one no-op, then the second read command;
  - two no-ops, then a ready poll.
- R6: The page-write prologue runs as follows after the reset script:
  - write sequence code, then write command;
  - one no-op, then the four address bytes;
  - two no-ops, then a ready poll.
- R7: Page program runs its body after the reset script: program sequence code, program command, two no-ops, a ready poll. The status phase follows.
- R8: Block erase runs its body after the reset script:
  - erase sequence code, then block-address command, then one no-op;
  - address bits 23:16, then bits 31:24 (the 2K-page number, low byte first);
  - one no-op, erase-start command, two no-ops, a ready poll.
  The status phase follows.
- R9: The status phase runs:
  - flush sequence code, flush command;
  - ECC configuration written with the read-mode value ORed with 4;
  - five no-ops;
  - two reads of the data register, then one read of the auxiliary status register;
  - a data-end write of zero, one no-op, a ready poll, and a final no-op.
- R10: The status passes when the first word equals the primary good value and the second and third words both equal the secondary good value. A mismatch sets `failFlag`, which then stays set across later operations. A `failClr` pulse while idle clears it on the next cycle.
- R11: A no-op write is a write of zero to the no-op register offset. While `busy` is high, every cycle carries exactly one bus access. `done` pulses for one cycle, with `busy` low, in the cycle after the last access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation request |
| reqOp | input | 2 | 0 page-read prologue, 1 page-write prologue, 2 program, 3 erase |
| reqAddr | input | 32 | Packed device address |
| failClr | input | 1 | Clears the sticky fail flag |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle completion pulse |
| failFlag | output | 1 | Sticky status failure |
| busWr | output | 1 | Bus write strobe |
| busRd | output | 1 | Bus read strobe |
| busAddr | output | ADDR_W | Register offset |
| busWrData | output | DATA_W | Write data |
| busRdData | input | DATA_W | Read data, sampled at the clock edge that ends a read cycle |

## Verification
Each bus access shows on the outputs in the cycle after the edge that chose it. The bench samples it at the falling edge and compares it with the head of a queue of expected accesses, built from the requirements. The response to a read is placed on `busRdData` at that same falling edge, so it is stable at the next rising edge, where the sequencer samples it. The poll responder returns "ready" on the read that must be ignored, and then a chosen number of not-ready words. `done` is expected at the first falling edge after the queue empties. `failFlag` is checked in that same cycle, since it settles on the status reads. A clear is checked one cycle after the `failClr` pulse.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {OP_RD, OP_WR, OP_PRG, OP_ERS} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RST, ST_BODY, ST_TAIL} state_e;
  typedef enum logic [1:0] {K_WR, K_RD, K_POLL} kind_e;
  typedef enum logic [3:0] {RG_CTRL, RG_SEQ, RG_CMD, RG_ADDR, RG_NOP,
                            RG_ECC, RG_DATA, RG_AUX, RG_END} reg_e;
  typedef enum logic [4:0] {V_ZERO, V_CTRLEN, V_SEQRST, V_CMDRST, V_SEQRD,
                            V_CMDRD, V_CMDRD2, V_SEQWR, V_CMDWR, V_SEQPRG,
                            V_CMDPRG, V_SEQERS, V_CMDBLK, V_CMDERS, V_SEQFLS,
                            V_CMDFLS, V_ECCRD, V_AB0, V_AB1, V_AB2, V_AB3} val_e;
  typedef enum logic [1:0] {C_NONE, C_PRI, C_SEC} chk_e;

  typedef struct packed {
    kind_e kind;
    reg_e  regSel;
    val_e  valSel;
    chk_e  chk;
    logic  last;
  } uop_t;

  typedef struct packed {
    logic  wrEn;
    logic  rdEn;
    reg_e  regSel;
    val_e  valSel;
    chk_e  chk;
    logic  start;
  } strobe_t;

  function automatic uop_t uWr(reg_e r, val_e v, logic l);
    return '{kind: K_WR, regSel: r, valSel: v, chk: C_NONE, last: l};
  endfunction

  function automatic uop_t uNop(logic l);
    return uWr(RG_NOP, V_ZERO, l);
  endfunction

  function automatic uop_t uRd(reg_e r, chk_e c, logic l);
    return '{kind: K_RD, regSel: r, valSel: V_ZERO, chk: c, last: l};
  endfunction

  function automatic uop_t uPoll(logic l);
    return '{kind: K_POLL, regSel: RG_CTRL, valSel: V_ZERO, chk: C_NONE, last: l};
  endfunction

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [1:0]    reqOp,
  input  logic          readyHit,
  output strobe_t       strobe,
  output logic          busy,
  output logic          done
);

  state_e           state;
  op_e              opReg;
  logic [IDX_W-1:0] idx;
  logic             pollSeen;
  uop_t             cur;
  logic             advance;

  // script decode: one micro-op per (segment, operation, step)
  always_comb begin
    cur = uNop(1'b1);
    unique case (state)
      ST_RST: begin
        case (idx)
          4'd0: cur = uWr(RG_CTRL, V_CTRLEN, 1'b0);
          4'd1: cur = uWr(RG_SEQ, V_SEQRST, 1'b0);
          4'd2: cur = uWr(RG_CMD, V_CMDRST, 1'b0);
          4'd3, 4'd4: cur = uNop(1'b0);
          4'd5: cur = uPoll(1'b0);
          default: cur = uNop(1'b1);
        endcase
      end
      ST_BODY: begin
        unique case (opReg)
          OP_RD: begin
            case (idx)
              4'd0: cur = uWr(RG_SEQ, V_SEQRD, 1'b0);
              4'd1: cur = uWr(RG_CMD, V_CMDRD, 1'b0);
              4'd3: cur = uWr(RG_ADDR, V_AB0, 1'b0);
              4'd4: cur = uWr(RG_ADDR, V_AB1, 1'b0);
              4'd5: cur = uWr(RG_ADDR, V_AB2, 1'b0);
              4'd6: cur = uWr(RG_ADDR, V_AB3, 1'b0);
              4'd8: cur = uWr(RG_CMD, V_CMDRD2, 1'b0);
              4'd11: cur = uPoll(1'b1);
              default: cur = uNop(1'b0);
            endcase
          end
          OP_WR: begin
            case (idx)
              4'd0: cur = uWr(RG_SEQ, V_SEQWR, 1'b0);
              4'd1: cur = uWr(RG_CMD, V_CMDWR, 1'b0);
              4'd3: cur = uWr(RG_ADDR, V_AB0, 1'b0);
              4'd4: cur = uWr(RG_ADDR, V_AB1, 1'b0);
              4'd5: cur = uWr(RG_ADDR, V_AB2, 1'b0);
              4'd6: cur = uWr(RG_ADDR, V_AB3, 1'b0);
              4'd9: cur = uPoll(1'b1);
              default: cur = uNop(1'b0);
            endcase
          end
          OP_PRG: begin
            case (idx)
              4'd0: cur = uWr(RG_SEQ, V_SEQPRG, 1'b0);
              4'd1: cur = uWr(RG_CMD, V_CMDPRG, 1'b0);
              4'd4: cur = uPoll(1'b1);
              default: cur = uNop(1'b0);
            endcase
          end
          default: begin
            case (idx)
              4'd0: cur = uWr(RG_SEQ, V_SEQERS, 1'b0);
              4'd1: cur = uWr(RG_CMD, V_CMDBLK, 1'b0);
              4'd3: cur = uWr(RG_ADDR, V_AB2, 1'b0);
              4'd4: cur = uWr(RG_ADDR, V_AB3, 1'b0);
              4'd6: cur = uWr(RG_CMD, V_CMDERS, 1'b0);
              4'd9: cur = uPoll(1'b1);
              default: cur = uNop(1'b0);
            endcase
          end
        endcase
      end
      ST_TAIL: begin
        case (idx)
          4'd0: cur = uWr(RG_SEQ, V_SEQFLS, 1'b0);
          4'd1: cur = uWr(RG_CMD, V_CMDFLS, 1'b0);
          4'd2: cur = uWr(RG_ECC, V_ECCRD, 1'b0);
          4'd8: cur = uRd(RG_DATA, C_PRI, 1'b0);
          4'd9: cur = uRd(RG_DATA, C_SEC, 1'b0);
          4'd10: cur = uRd(RG_AUX, C_SEC, 1'b0);
          4'd11: cur = uWr(RG_END, V_ZERO, 1'b0);
          4'd13: cur = uPoll(1'b0);
          4'd14: cur = uNop(1'b1);
          default: cur = uNop(1'b0);
        endcase
      end
      default: cur = uNop(1'b1);
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign advance = busy && ((cur.kind != K_POLL) || (pollSeen && readyHit));

  always_comb begin
    strobe.wrEn   = busy && (cur.kind == K_WR);
    strobe.rdEn   = busy && (cur.kind != K_WR);
    strobe.regSel = cur.regSel;
    strobe.valSel = cur.valSel;
    strobe.chk    = busy ? cur.chk : C_NONE;
    strobe.start  = !busy && reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      opReg    <= OP_RD;
      idx      <= '0;
      pollSeen <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (reqValid) begin
          opReg    <= op_e'(reqOp);
          state    <= ST_RST;
          idx      <= '0;
          pollSeen <= 1'b0;
        end
      end else if (advance) begin
        pollSeen <= 1'b0;
        if (cur.last) begin
          idx <= '0;
          if (state == ST_RST) begin
            state <= ST_BODY;
          end else if (state == ST_BODY && (opReg == OP_PRG || opReg == OP_ERS)) begin
            state <= ST_TAIL;
          end else begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (cur.kind == K_POLL) begin
        pollSeen <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          ADDR_W     = 13,
  parameter int          READY_BIT  = 7,
  parameter logic [12:0] OFS_CTRL   = 13'h1032,
  parameter logic [12:0] OFS_SEQ    = 13'h1034,
  parameter logic [12:0] OFS_CMD    = 13'h1036,
  parameter logic [12:0] OFS_ADDR   = 13'h1038,
  parameter logic [12:0] OFS_NOP    = 13'h1060,
  parameter logic [12:0] OFS_ECC    = 13'h1040,
  parameter logic [12:0] OFS_DATA   = 13'h0800,
  parameter logic [12:0] OFS_AUX    = 13'h107E,
  parameter logic [12:0] OFS_END    = 13'h1066,
  parameter logic [15:0] CTRL_EN    = 16'h0011,
  parameter logic [15:0] SEQ_RST    = 16'h0001,
  parameter logic [15:0] CMD_RST    = 16'h00F0,
  parameter logic [15:0] SEQ_RD     = 16'h0003,
  parameter logic [15:0] CMD_RD     = 16'h0010,
  parameter logic [15:0] CMD_RD2    = 16'h0038,
  parameter logic [15:0] SEQ_WR     = 16'h0005,
  parameter logic [15:0] CMD_WR     = 16'h0080,
  parameter logic [15:0] SEQ_PRG    = 16'h0007,
  parameter logic [15:0] CMD_PRG    = 16'h0019,
  parameter logic [15:0] SEQ_ERS    = 16'h0009,
  parameter logic [15:0] CMD_BLK    = 16'h0060,
  parameter logic [15:0] CMD_ERS    = 16'h00D0,
  parameter logic [15:0] SEQ_FLS    = 16'h000B,
  parameter logic [15:0] CMD_FLS    = 16'h0070,
  parameter logic [15:0] ECC_RDMODE = 16'h8000,
  parameter logic [15:0] GOOD_PRI   = 16'h00C3,
  parameter logic [15:0] GOOD_SEC   = 16'h0081
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [31:0]       reqAddr,
  input  logic              failClr,
  input  logic [DATA_W-1:0] busRdData,
  output logic              readyHit,
  output logic              busWr,
  output logic              busRd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              failFlag
);

  localparam logic [15:0] ECC_VAL = ECC_RDMODE | 16'h0004;

  logic [31:0]       addrReg;
  logic [7:0]        addrByte;
  logic [15:0]       wrVal;
  logic [12:0]       ofs;
  logic              statusBad;

  always_ff @(posedge clk) begin
    if (!rstN)             addrReg <= '0;
    else if (strobe.start) addrReg <= reqAddr;
  end

  always_comb begin
    unique case (strobe.valSel)
      V_AB0:   addrByte = addrReg[7:0];
      V_AB1:   addrByte = addrReg[15:8];
      V_AB2:   addrByte = addrReg[23:16];
      V_AB3:   addrByte = addrReg[31:24];
      default: addrByte = 8'h00;
    endcase
  end

  always_comb begin
    unique case (strobe.valSel)
      V_CTRLEN: wrVal = CTRL_EN;
      V_SEQRST: wrVal = SEQ_RST;
      V_CMDRST: wrVal = CMD_RST;
      V_SEQRD:  wrVal = SEQ_RD;
      V_CMDRD:  wrVal = CMD_RD;
      V_CMDRD2: wrVal = CMD_RD2;
      V_SEQWR:  wrVal = SEQ_WR;
      V_CMDWR:  wrVal = CMD_WR;
      V_SEQPRG: wrVal = SEQ_PRG;
      V_CMDPRG: wrVal = CMD_PRG;
      V_SEQERS: wrVal = SEQ_ERS;
      V_CMDBLK: wrVal = CMD_BLK;
      V_CMDERS: wrVal = CMD_ERS;
      V_SEQFLS: wrVal = SEQ_FLS;
      V_CMDFLS: wrVal = CMD_FLS;
      V_ECCRD:  wrVal = ECC_VAL;
      V_AB0, V_AB1, V_AB2, V_AB3: wrVal = {8'h00, addrByte};
      default:  wrVal = 16'h0000;
    endcase
  end

  always_comb begin
    unique case (strobe.regSel)
      RG_CTRL: ofs = OFS_CTRL;
      RG_SEQ:  ofs = OFS_SEQ;
      RG_CMD:  ofs = OFS_CMD;
      RG_ADDR: ofs = OFS_ADDR;
      RG_ECC:  ofs = OFS_ECC;
      RG_DATA: ofs = OFS_DATA;
      RG_AUX:  ofs = OFS_AUX;
      RG_END:  ofs = OFS_END;
      default: ofs = OFS_NOP;
    endcase
  end

  assign busWr     = strobe.wrEn;
  assign busRd     = strobe.rdEn;
  assign busAddr   = ADDR_W'(ofs);
  assign busWrData = strobe.wrEn ? DATA_W'(wrVal) : '0;
  assign readyHit  = busRdData[READY_BIT];

  always_comb begin
    unique case (strobe.chk)
      C_PRI:   statusBad = strobe.rdEn && (busRdData != DATA_W'(GOOD_PRI));
      C_SEC:   statusBad = strobe.rdEn && (busRdData != DATA_W'(GOOD_SEC));
      default: statusBad = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          failFlag <= 1'b0;
    else if (statusBad) failFlag <= 1'b1;
    else if (failClr)   failFlag <= 1'b0;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          ADDR_W     = 13,
  parameter int          READY_BIT  = 7,
  parameter logic [12:0] OFS_CTRL   = 13'h1032,
  parameter logic [12:0] OFS_SEQ    = 13'h1034,
  parameter logic [12:0] OFS_CMD    = 13'h1036,
  parameter logic [12:0] OFS_ADDR   = 13'h1038,
  parameter logic [12:0] OFS_NOP    = 13'h1060,
  parameter logic [12:0] OFS_ECC    = 13'h1040,
  parameter logic [12:0] OFS_DATA   = 13'h0800,
  parameter logic [12:0] OFS_AUX    = 13'h107E,
  parameter logic [12:0] OFS_END    = 13'h1066,
  parameter logic [15:0] CTRL_EN    = 16'h0011,
  parameter logic [15:0] SEQ_RST    = 16'h0001,
  parameter logic [15:0] CMD_RST    = 16'h00F0,
  parameter logic [15:0] SEQ_RD     = 16'h0003,
  parameter logic [15:0] CMD_RD     = 16'h0010,
  parameter logic [15:0] CMD_RD2    = 16'h0038,
  parameter logic [15:0] SEQ_WR     = 16'h0005,
  parameter logic [15:0] CMD_WR     = 16'h0080,
  parameter logic [15:0] SEQ_PRG    = 16'h0007,
  parameter logic [15:0] CMD_PRG    = 16'h0019,
  parameter logic [15:0] SEQ_ERS    = 16'h0009,
  parameter logic [15:0] CMD_BLK    = 16'h0060,
  parameter logic [15:0] CMD_ERS    = 16'h00D0,
  parameter logic [15:0] SEQ_FLS    = 16'h000B,
  parameter logic [15:0] CMD_FLS    = 16'h0070,
  parameter logic [15:0] ECC_RDMODE = 16'h8000,
  parameter logic [15:0] GOOD_PRI   = 16'h00C3,
  parameter logic [15:0] GOOD_SEC   = 16'h0081
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [31:0]       reqAddr,
  input  logic              failClr,
  output logic              busy,
  output logic              done,
  output logic              failFlag,
  output logic              busWr,
  output logic              busRd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] busRdData
);

  strobe_t strobe;
  logic    readyHit;

  flash_seq_ctrl #(.IDX_W(4)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .readyHit(readyHit), .strobe(strobe), .busy(busy), .done(done)
  );

  flash_seq_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .READY_BIT(READY_BIT),
    .OFS_CTRL(OFS_CTRL), .OFS_SEQ(OFS_SEQ), .OFS_CMD(OFS_CMD),
    .OFS_ADDR(OFS_ADDR), .OFS_NOP(OFS_NOP), .OFS_ECC(OFS_ECC),
    .OFS_DATA(OFS_DATA), .OFS_AUX(OFS_AUX), .OFS_END(OFS_END),
    .CTRL_EN(CTRL_EN), .SEQ_RST(SEQ_RST), .CMD_RST(CMD_RST),
    .SEQ_RD(SEQ_RD), .CMD_RD(CMD_RD), .CMD_RD2(CMD_RD2),
    .SEQ_WR(SEQ_WR), .CMD_WR(CMD_WR), .SEQ_PRG(SEQ_PRG), .CMD_PRG(CMD_PRG),
    .SEQ_ERS(SEQ_ERS), .CMD_BLK(CMD_BLK), .CMD_ERS(CMD_ERS),
    .SEQ_FLS(SEQ_FLS), .CMD_FLS(CMD_FLS), .ECC_RDMODE(ECC_RDMODE),
    .GOOD_PRI(GOOD_PRI), .GOOD_SEC(GOOD_SEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .failClr(failClr), .busRdData(busRdData), .readyHit(readyHit),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .failFlag(failFlag)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int          DATA_W  = 16,
  parameter int          ADDR_W  = 13,
  parameter logic [12:0] OFS_NOP = 13'h1060
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              failClr,
  input logic              busy,
  input logic              done,
  input logic              failFlag,
  input logic              busWr,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData
);

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);                                   // R1
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busWr && !busRd));                                   // R1
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $onehot({busWr, busRd}));                               // R11
  AST_NOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFS_NOP)) |-> (busWrData == '0));   // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));                                // R11
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !failClr) |=> failFlag);                            // R10
  AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (failClr && !busy) |=> !failFlag);                               // R10

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_NOP(OFS_NOP)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .failClr(failClr),
  .busy(busy), .done(done), .failFlag(failFlag), .busWr(busWr),
  .busRd(busRd), .busAddr(busAddr), .busWrData(busWrData)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;

  localparam int DW = 16;
  localparam int AW = 13;
  localparam int RDY = 7;
  localparam logic [12:0] A_CTRL = 13'h1032, A_SEQ = 13'h1034, A_CMD = 13'h1036,
    A_ADDR = 13'h1038, A_NOP = 13'h1060, A_ECC = 13'h1040, A_DATA = 13'h0800,
    A_AUX = 13'h107E, A_END = 13'h1066;
  localparam logic [15:0] V_CTRLEN = 16'h0011, V_SEQRST = 16'h0001, V_CMDRST = 16'h00F0,
    V_SEQRD = 16'h0003, V_CMDRD = 16'h0010, V_CMDRD2 = 16'h0038, V_SEQWR = 16'h0005,
    V_CMDWR = 16'h0080, V_SEQPRG = 16'h0007, V_CMDPRG = 16'h0019, V_SEQERS = 16'h0009,
    V_CMDBLK = 16'h0060, V_CMDERS = 16'h00D0, V_SEQFLS = 16'h000B, V_CMDFLS = 16'h0070,
    V_ECCRD = 16'h8004, G_PRI = 16'h00C3, G_SEC = 16'h0081;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [31:0] reqAddr = 32'd0;
  logic failClr = 1'b0;
  logic busy, done, failFlag, busWr, busRd;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWrData;
  logic [DW-1:0] busRdData = '0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(
    .DATA_W(DW), .ADDR_W(AW), .READY_BIT(RDY),
    .OFS_CTRL(A_CTRL), .OFS_SEQ(A_SEQ), .OFS_CMD(A_CMD), .OFS_ADDR(A_ADDR),
    .OFS_NOP(A_NOP), .OFS_ECC(A_ECC), .OFS_DATA(A_DATA), .OFS_AUX(A_AUX),
    .OFS_END(A_END), .CTRL_EN(V_CTRLEN), .SEQ_RST(V_SEQRST), .CMD_RST(V_CMDRST),
    .SEQ_RD(V_SEQRD), .CMD_RD(V_CMDRD), .CMD_RD2(V_CMDRD2), .SEQ_WR(V_SEQWR),
    .CMD_WR(V_CMDWR), .SEQ_PRG(V_SEQPRG), .CMD_PRG(V_CMDPRG), .SEQ_ERS(V_SEQERS),
    .CMD_BLK(V_CMDBLK), .CMD_ERS(V_CMDERS), .SEQ_FLS(V_SEQFLS), .CMD_FLS(V_CMDFLS),
    .ECC_RDMODE(16'h8000), .GOOD_PRI(G_PRI), .GOOD_SEC(G_SEC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .failClr(failClr), .busy(busy), .done(done), .failFlag(failFlag),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData)
  );

  typedef struct {int kind; int addr; int data; string req;} ex_t; // kind 0 wr, 1 rd, 2 poll
  ex_t q[$];
  int checks = 0;
  int errors = 0;
  int readyAfter = 0;
  int pollReads = 0;
  bit doneDue = 0;
  bit doneSeen = 0;

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic pw(int a, int d, string r); q.push_back('{0, a, d, r}); endtask
  task automatic pr(int a, int d, string r); q.push_back('{1, a, d, r}); endtask
  task automatic pp(string r); q.push_back('{2, A_CTRL, 0, r}); endtask
  task automatic nop(string r); pw(A_NOP, 0, r); endtask

  task automatic addResetScript();  // R2
    pw(A_CTRL, V_CTRLEN, "R2"); pw(A_SEQ, V_SEQRST, "R2"); pw(A_CMD, V_CMDRST, "R2");
    nop("R2"); nop("R2"); pp("R3"); nop("R2");
  endtask

  task automatic addAddr(logic [31:0] a);  // R4
    for (int i = 0; i < 4; i++) pw(A_ADDR, int'(a[8*i +: 8]), "R4");
  endtask

  task automatic addTail(int s0, int s1, int s2);  // R9
    pw(A_SEQ, V_SEQFLS, "R9"); pw(A_CMD, V_CMDFLS, "R9"); pw(A_ECC, V_ECCRD, "R9");
    for (int i = 0; i < 5; i++) nop("R9");
    pr(A_DATA, s0, "R9"); pr(A_DATA, s1, "R9"); pr(A_AUX, s2, "R9");
    pw(A_END, 0, "R9"); nop("R9"); pp("R9"); nop("R9");
  endtask

  task automatic buildScript(int op, logic [31:0] a, int s0, int s1, int s2);
    addResetScript();
    case (op)
      0: begin  // R5
        pw(A_SEQ, V_SEQRD, "R5"); pw(A_CMD, V_CMDRD, "R5"); nop("R5"); addAddr(a);
        nop("R5"); pw(A_CMD, V_CMDRD2, "R5"); nop("R5"); nop("R5"); pp("R5");
      end
      1: begin  // R6
        pw(A_SEQ, V_SEQWR, "R6"); pw(A_CMD, V_CMDWR, "R6"); nop("R6"); addAddr(a);
        nop("R6"); nop("R6"); pp("R6");
      end
      2: begin  // R7
        pw(A_SEQ, V_SEQPRG, "R7"); pw(A_CMD, V_CMDPRG, "R7"); nop("R7"); nop("R7"); pp("R7");
        addTail(s0, s1, s2);
      end
      default: begin  // R8
        pw(A_SEQ, V_SEQERS, "R8"); pw(A_CMD, V_CMDBLK, "R8"); nop("R8");
        pw(A_ADDR, int'(a[23:16]), "R8"); pw(A_ADDR, int'(a[31:24]), "R8");
        nop("R8"); pw(A_CMD, V_CMDERS, "R8"); nop("R8"); nop("R8"); pp("R8");
        addTail(s0, s1, s2);
      end
    endcase
  endtask

  // bus monitor and flash responder, one step per cycle at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (busWr || busRd) begin
        checks++;
        if (q.size() == 0) begin
          fail("R1", "unexpected access addr", int'(busAddr), 0);
        end else begin
          ex_t e;
          e = q[0];
          busRdData <= '0;
          if (e.kind == 2) begin
            if (!busRd || busWr || int'(busAddr) != e.addr)
              fail("R3", "poll read addr", int'(busAddr), e.addr);
            pollReads++;
            if (pollReads == 1) begin
              busRdData <= 16'h0001 << RDY;
            end else if (pollReads - 2 >= readyAfter) begin
              busRdData <= (16'h0001 << RDY) | 16'h0004;
              pollReads = 0;
              void'(q.pop_front());
            end else begin
              busRdData <= 16'h0004;
            end
          end else if (e.kind == 1) begin
            if (!busRd || busWr || int'(busAddr) != e.addr)
              fail(e.req, "status read addr", int'(busAddr), e.addr);
            busRdData <= DW'(e.data);
            void'(q.pop_front());
          end else begin
            if (!busWr || busRd || int'(busAddr) != e.addr)
              fail(e.req, "write addr", int'(busAddr), e.addr);
            else if (int'(busWrData) != e.data)
              fail(e.req, "write data", int'(busWrData), e.data);
            void'(q.pop_front());
          end
          if (q.size() == 0) doneDue = 1;
        end
      end else if (doneDue) begin
        checks++;
        if (!done || busy) fail("R11", "done/busy after last access", {done, busy}, 2'b10);
        doneDue = 0;
        doneSeen = 1;
      end else if (busy) begin
        checks++;
        fail("R11", "idle cycle while busy", 0, 1);
      end else if (done) begin
        checks++;
        fail("R11", "spurious done", 1, 0);
      end
    end
  end

  task automatic runOp(int op, logic [31:0] a, int ra, int s0, int s1, int s2,
                       bit expFail, bit poke);
    readyAfter = ra;
    buildScript(op, a, s0, s1, s2);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    checks++;
    if (!busy) fail("R1", "busy after request", 0, 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      reqValid = 1'b1; reqOp = 2'(3 - op); reqAddr = ~a;  // R1: ignored while busy
      @(negedge clk);
      reqValid = 1'b0;
    end
    wait (doneSeen);
    doneSeen = 0;
    checks++;
    if (failFlag != expFail) fail("R10", "failFlag after op", failFlag, expFail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (busy || done || failFlag || busWr || busRd)
      fail("R1", "reset state", {busy, done, failFlag, busWr, busRd}, 0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(0, 32'h0080_0108, 0, 0, 0, 0, 0, 0);                  // R5 R4 R3
    runOp(1, 32'h1234_5678, 2, 0, 0, 0, 0, 1);                  // R6 R1
    repeat (3) @(negedge clk);
    checks++;
    if (busy) fail("R1", "request during busy started an op", 1, 0);
    runOp(2, 32'h0000_0000, 1, G_PRI, G_SEC, G_SEC, 0, 0);      // R7 R9
    runOp(3, 32'hA1B2_0000, 0, G_PRI, G_SEC, 16'h0080, 1, 0);   // R8 R10 third word bad
    runOp(2, 32'h0, 0, G_PRI, G_SEC, G_SEC, 1, 0);              // R10 sticky
    @(negedge clk); failClr = 1'b1;
    @(negedge clk); failClr = 1'b0;
    checks++;
    if (failFlag) fail("R10", "clear", 1, 0);
    runOp(3, 32'h00FF_1234, 3, 16'h00C2, G_SEC, G_SEC, 1, 0);   // R10 first word bad
    @(negedge clk); failClr = 1'b1;
    @(negedge clk); failClr = 1'b0;
    runOp(2, 32'h0, 0, G_PRI, 16'h0000, G_SEC, 1, 0);           // R10 second word bad
    @(negedge clk); failClr = 1'b1;
    @(negedge clk); failClr = 1'b0;
    runOp(3, 32'h7F00_0000, 1, G_PRI, G_SEC, G_SEC, 0, 0);      // R8 R10 pass after clear
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) fail("R11", "expected accesses left", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired actual=%h expected=%h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

endmodule